// File: doc/BRIEF.md
# Two-Plane NAND Block Erase Sequencer

This block runs a block erase on a raw 8-bit NAND flash bus for one block, or for two blocks at once when they sit in different planes. A host pulses `start` with one or two block numbers. For each block the sequencer writes the erase setup command and three row-address bytes. It then writes a single confirm command that starts every selected erase together.

Erase completion is found in one of two ways, chosen per request. The sequencer can wait for the ready/busy pin to return high and then read status once. It can also read status over and over until the ready bit is set. The pass/fail bit of the final status byte is reported, with a timeout error if the erase never finishes inside a programmable number of clocks. A two-plane request that cannot be legal is refused before any bus activity.

Top module: `nand_dual_erase`

## Requirements
- R1: A single-plane request produces exactly these bus writes: command 0x60, three address bytes for `blk_a`, command 0xD0.
- R2: A two-plane request produces command 0x60 and three address bytes for `blk_a`, then command 0x60 and three address bytes for `blk_b`, then one command 0xD0.
- R3: The row word for a block is the block number shifted left by 6, so row bits 5:0 (the page bits) are zero and block bit 0 (the plane select) lands on row bit 6. Address bytes go out as row bits 7:0, 15:8, then 23:16.
- R4: A two-plane request whose two blocks share the same bit 0 sets `err_plane` and pulses `done`, with CE# kept high and no WE# pulse.
- R5: A two-plane request whose blocks differ in any bit above bit 0 is refused in the same way as R4.
- R6: In pin mode (`use_poll`=0), the sequencer waits for R/B# high, then writes command 0x70 once and reads one status byte. `fail` equals status bit 0.
- R7: In poll mode (`use_poll`=1), the sequencer repeats command 0x70 plus one read until a status byte has bit 6 set. `fail` equals bit 0 of that byte.
- R8: If the erase is not ready within `timeout_lim` clocks after the confirm, `err_timeout` is set, `fail` is clear and `done` pulses.
- R9: CLE and ALE are never high together, WE# and RE# are never low together, and CE# is low whenever WE# or RE# is low.
- R10: While idle, and after reset, CE#, WE# and RE# are high, CLE and ALE are low, and `busy` is low.
- R11: `done` is a one-clock pulse, and `busy` is low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request (sampled while idle) |
| two_plane | input | 1 | Erase both `blk_a` and `blk_b` |
| use_poll | input | 1 | 1: poll status for ready; 0: watch R/B# |
| blk_a | input | BLK_W | First block number |
| blk_b | input | BLK_W | Second block number (two-plane only) |
| timeout_lim | input | TO_W | Clocks allowed for the erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Status reported erase failure |
| err_plane | output | 1 | Two-plane request refused |
| err_timeout | output | 1 | Ready never returned |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| rb_n | input | 1 | Ready/busy from flash, low while busy |
| nand_io | inout | 8 | Flash data bus |

## Verification
The hardest case to reach is a poll-mode erase that needs several status reads before the ready bit appears. The repeated 0x70 cycles must keep running while the timeout counter is also active. The bench's flash model holds R/B# low for a chosen number of clocks after it sees 0xD0 and reports that state in status bit 6. Random busy lengths in poll mode therefore force varying read counts. Very long busy lengths with a small limit drive both wait modes into the timeout exit.

// File: rtl/nde_pkg.sv
package nde_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_READ = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [7:0] data;
    } bus_op_t;

    localparam logic [7:0] CMD_ERS_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERS_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS    = 8'h70;

    localparam int PAGE_BITS = 6;
    localparam int ROW_W     = 24;
    localparam int READY_BIT = 6;
    localparam int FAIL_BIT  = 0;

    localparam logic [3:0] STEP_A_LAST = 4'd3;
    localparam logic [3:0] STEP_GO     = 4'd8;

    // Op issued at each position of the command/address phase.
    function automatic bus_op_t step_op(input logic [3:0] step,
                                        input logic [ROW_W-1:0] row0,
                                        input logic [ROW_W-1:0] row1);
        bus_op_t o;
        o.kind = OP_ADDR;
        o.data = 8'h00;
        case (step)
            4'd0, 4'd4: begin o.kind = OP_CMD; o.data = CMD_ERS_SETUP; end
            4'd1: o.data = row0[7:0];
            4'd2: o.data = row0[15:8];
            4'd3: o.data = row0[23:16];
            4'd5: o.data = row1[7:0];
            4'd6: o.data = row1[15:8];
            4'd7: o.data = row1[23:16];
            default: begin o.kind = OP_CMD; o.data = CMD_ERS_GO; end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/nde_bus_cycle.sv
module nde_bus_cycle
    import nde_pkg::*;
#(
    parameter int PHASE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  bus_op_t    op,
    output logic       ready,
    output logic       op_done,
    output logic [7:0] rd_data,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic       io_oe,
    output logic [7:0] io_do,
    input  logic [7:0] io_di
);
    localparam int CW = $clog2(PHASE_CYC + 1);

    typedef enum logic [1:0] {B_IDLE, B_LOW, B_HIGH} bst_e;

    bst_e           st;
    bus_op_t        cur;
    logic [CW-1:0]  cnt;
    logic           last;

    assign last = (cnt == CW'(PHASE_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= B_IDLE;
            cur     <= '0;
            cnt     <= '0;
            rd_data <= '0;
        end else begin
            case (st)
                B_IDLE: if (op_valid) begin
                    cur <= op;
                    cnt <= '0;
                    st  <= B_LOW;
                end
                B_LOW: if (last) begin
                    cnt <= '0;
                    st  <= B_HIGH;
                    if (cur.kind == OP_READ) rd_data <= io_di;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                B_HIGH: if (last) begin
                    st <= B_IDLE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    assign ready   = (st == B_IDLE);
    assign op_done = (st == B_HIGH) && last;
    assign cle     = (st != B_IDLE) && (cur.kind == OP_CMD);
    assign ale     = (st != B_IDLE) && (cur.kind == OP_ADDR);
    assign we_n    = !((st == B_LOW) && (cur.kind != OP_READ));
    assign re_n    = !((st == B_LOW) && (cur.kind == OP_READ));
    assign io_oe   = (st != B_IDLE) && (cur.kind != OP_READ);
    assign io_do   = cur.data;
endmodule

// File: rtl/nde_busy_timer.sv
module nde_busy_timer #(
    parameter int TO_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit);
endmodule

// File: rtl/nand_dual_erase.sv
module nand_dual_erase
    import nde_pkg::*;
#(
    parameter int BLK_W      = 11,
    parameter int PHASE_CYC  = 2,
    parameter int SETTLE_CYC = 4,
    parameter int TO_W       = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             two_plane,
    input  logic             use_poll,
    input  logic [BLK_W-1:0] blk_a,
    input  logic [BLK_W-1:0] blk_b,
    input  logic [TO_W-1:0]  timeout_lim,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             err_plane,
    output logic             err_timeout,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    input  logic             rb_n,
    inout  wire  [7:0]       nand_io
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_CMDS, S_SETTLE, S_WAIT, S_STCMD, S_STRD
    } st_e;

    st_e              st;
    logic [3:0]       step;
    logic [ROW_W-1:0] row0, row1;
    logic             two_q, poll_q, rd_sent;
    logic [TO_W-1:0]  lim_q;
    logic [SW-1:0]    settle_cnt;
    logic [1:0]       rb_sync;

    logic             op_valid, bus_ready, op_done, io_oe;
    bus_op_t          op;
    logic [7:0]       rd_data, io_do;
    logic             tmr_expired, tmr_run, tmr_clear;
    logic             conflict;

    assign conflict = (blk_a[0] == blk_b[0]) ||
                      (blk_a[BLK_W-1:1] != blk_b[BLK_W-1:1]);

    nde_bus_cycle #(.PHASE_CYC(PHASE_CYC)) bus_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op),
        .ready(bus_ready), .op_done(op_done), .rd_data(rd_data),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .io_oe(io_oe), .io_do(io_do), .io_di(nand_io)
    );

    assign nand_io = io_oe ? io_do : 8'bz;

    assign tmr_clear = (st == S_CMDS);
    assign tmr_run   = (st == S_SETTLE) || (st == S_WAIT) ||
                       (st == S_STCMD)  || (st == S_STRD);

    nde_busy_timer #(.TO_W(TO_W)) tmr_i (
        .clk(clk), .rst(rst), .clear(tmr_clear), .run(tmr_run),
        .limit(lim_q), .expired(tmr_expired)
    );

    always_comb begin
        op_valid = 1'b0;
        op       = step_op(step, row0, row1);
        case (st)
            S_CMDS:  op_valid = bus_ready;
            S_STCMD: begin
                op.kind  = OP_CMD;
                op.data  = CMD_STATUS;
                op_valid = bus_ready && !(poll_q && tmr_expired);
            end
            S_STRD: begin
                op.kind  = OP_READ;
                op.data  = 8'h00;
                op_valid = bus_ready && !rd_sent;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            step        <= '0;
            row0        <= '0;
            row1        <= '0;
            two_q       <= 1'b0;
            poll_q      <= 1'b0;
            lim_q       <= '0;
            rd_sent     <= 1'b0;
            settle_cnt  <= '0;
            rb_sync     <= 2'b00;
            done        <= 1'b0;
            fail        <= 1'b0;
            err_plane   <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            rb_sync <= {rb_sync[0], rb_n};
            done    <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    fail        <= 1'b0;
                    err_timeout <= 1'b0;
                    if (two_plane && conflict) begin
                        err_plane <= 1'b1;
                        done      <= 1'b1;
                    end else begin
                        err_plane <= 1'b0;
                        row0      <= ROW_W'(blk_a) << PAGE_BITS;
                        row1      <= ROW_W'(blk_b) << PAGE_BITS;
                        two_q     <= two_plane;
                        poll_q    <= use_poll;
                        lim_q     <= timeout_lim;
                        step      <= '0;
                        st        <= S_CMDS;
                    end
                end
                S_CMDS: if (op_valid) begin
                    if (step == STEP_GO) begin
                        settle_cnt <= '0;
                        st         <= S_SETTLE;
                    end else if (step == STEP_A_LAST && !two_q) begin
                        step <= STEP_GO;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                S_SETTLE: begin
                    if (!bus_ready) begin
                        settle_cnt <= '0;
                    end else if (settle_cnt == SW'(SETTLE_CYC - 1)) begin
                        st <= poll_q ? S_STCMD : S_WAIT;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                S_WAIT: begin
                    if (rb_sync[1]) begin
                        st <= S_STCMD;
                    end else if (tmr_expired) begin
                        err_timeout <= 1'b1;
                        done        <= 1'b1;
                        st          <= S_IDLE;
                    end
                end
                S_STCMD: begin
                    if (poll_q && tmr_expired && bus_ready) begin
                        err_timeout <= 1'b1;
                        done        <= 1'b1;
                        st          <= S_IDLE;
                    end else if (op_valid) begin
                        rd_sent <= 1'b0;
                        st      <= S_STRD;
                    end
                end
                S_STRD: begin
                    if (op_valid) begin
                        rd_sent <= 1'b1;
                    end else if (rd_sent && op_done) begin
                        if (poll_q && !rd_data[READY_BIT]) begin
                            st <= S_STCMD;
                        end else begin
                            fail <= rd_data[FAIL_BIT];
                            done <= 1'b1;
                            st   <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy = (st != S_IDLE);
    assign ce_n = (st == S_IDLE);
endmodule

// File: rtl/nde_checker.sv
module nde_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic fail,
    input logic err_plane,
    input logic err_timeout,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n
);
    a_r9_cle_ale_excl: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));
    a_r9_we_re_excl: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));
    a_r9_ce_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> !ce_n);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ce_n && we_n && re_n && !cle && !ale));
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r4_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        err_plane |-> (ce_n && we_n));
    a_r8_timeout_no_fail: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> !fail);
endmodule

bind nand_dual_erase nde_checker chk_i (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .fail(fail),
    .err_plane(err_plane), .err_timeout(err_timeout), .ce_n(ce_n),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n)
);

// File: tb/nand_dual_erase_tb.sv
`timescale 1ns/1ps
module nand_dual_erase_tb_top;
    localparam int BLK_W = 11;
    localparam int TO_W  = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0, two_plane = 1'b0, use_poll = 1'b0;
    logic [BLK_W-1:0] blk_a = '0, blk_b = '0;
    logic [TO_W-1:0]  timeout_lim = '0;
    logic             busy, done, fail, err_plane, err_timeout;
    logic             ce_n, cle, ale, we_n, re_n;
    logic             rb_n;
    wire  [7:0]       nand_io;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    nand_dual_erase #(.BLK_W(BLK_W), .TO_W(TO_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .two_plane(two_plane),
        .use_poll(use_poll), .blk_a(blk_a), .blk_b(blk_b),
        .timeout_lim(timeout_lim), .busy(busy), .done(done), .fail(fail),
        .err_plane(err_plane), .err_timeout(err_timeout), .ce_n(ce_n),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .rb_n(rb_n),
        .nand_io(nand_io)
    );

    // ---------------- flash model ----------------
    logic [9:0] lg [0:63];
    int  lg_n = 0;
    int  rd_n = 0;
    logic [7:0] last_rd = 8'h00;
    int  go_seen = 0, go_ack = 0;
    int  busy_left = 0;
    int  busy_cyc = 10;
    logic fail_set = 1'b0;
    logic [7:0] st_byte;

    assign rb_n    = (busy_left == 0);
    assign st_byte = {1'b1, rb_n, 5'b0, fail_set};
    assign nand_io = re_n ? 8'bz : st_byte;

    always @(posedge we_n) begin
        if (!rst) begin
            if (lg_n < 64) lg[lg_n] = {cle, ale, nand_io};
            lg_n = lg_n + 1;
            if (cle && nand_io == 8'hD0) go_seen = go_seen + 1;
        end
    end

    always @(posedge re_n) begin
        if (!rst) begin
            rd_n    = rd_n + 1;
            last_rd = st_byte;
        end
    end

    always @(negedge clk) begin
        if (go_seen != go_ack) begin
            go_ack    = go_seen;
            busy_left = busy_cyc;
        end else if (busy_left > 0) begin
            busy_left = busy_left - 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [9:0] exp_entry(input bit two,
            input logic [BLK_W-1:0] a, input logic [BLK_W-1:0] b, input int i);
        logic [23:0] ra, rb;
        ra = 24'(a) << 6;
        rb = 24'(b) << 6;
        if (!two && i == 4) return {2'b10, 8'hD0};
        case (i)
            0, 4: return {2'b10, 8'h60};
            1: return {2'b01, ra[7:0]};
            2: return {2'b01, ra[15:8]};
            3: return {2'b01, ra[23:16]};
            5: return {2'b01, rb[7:0]};
            6: return {2'b01, rb[15:8]};
            7: return {2'b01, rb[23:16]};
            default: return {2'b10, 8'hD0};
        endcase
    endfunction

    task automatic run_case(input bit two, input logic [BLK_W-1:0] a,
            input logic [BLK_W-1:0] b, input bit poll, input bit fs,
            input int bc, input int lim, input bit exp_perr, input bit exp_to);
        int hn;
        bit seen;
        hn = two ? 9 : 5;
        @(negedge clk);
        lg_n = 0; rd_n = 0;
        busy_cyc = bc; fail_set = fs;
        two_plane = two; blk_a = a; blk_b = b; use_poll = poll;
        timeout_lim = TO_W'(lim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = done;
        for (int k = 0; k < 20000 && !seen; k++) begin
            @(negedge clk);
            seen = done;
        end
        chk(seen, "R11", "done seen", int'(seen), 1);
        chk(!busy, "R11", "busy low with done", int'(busy), 0);
        if (exp_perr) begin
            chk(err_plane, two && a[0] == b[0] ? "R4" : "R5", "err_plane", int'(err_plane), 1);
            chk(lg_n == 0, "R4", "no writes on reject", lg_n, 0);
        end else begin
            chk(!err_plane, "R2", "no err_plane", int'(err_plane), 0);
            for (int i = 0; i < hn; i++)
                chk(lg[i] == exp_entry(two, a, b, i), two ? "R2" : "R1",
                    "header write", int'(lg[i]), int'(exp_entry(two, a, b, i)));
            chk(lg[1][5:0] == 6'd0 && lg[1][6] == a[0], "R3", "page bits/plane bit",
                int'(lg[1][7:0]), int'({a[1:0], 6'd0}));
            chk(err_timeout == exp_to, "R8", "err_timeout", int'(err_timeout), int'(exp_to));
            if (exp_to) begin
                chk(!fail, "R8", "fail clear on timeout", int'(fail), 0);
            end else begin
                for (int i = hn; i < lg_n && i < 64; i++)
                    chk(lg[i] == {2'b10, 8'h70}, poll ? "R7" : "R6", "status cmd",
                        int'(lg[i]), 'h270);
                chk(lg_n - hn == rd_n, poll ? "R7" : "R6", "one read per 0x70",
                    rd_n, lg_n - hn);
                if (!poll) chk(rd_n == 1, "R6", "single status read", rd_n, 1);
                else chk(last_rd[6], "R7", "last read ready", int'(last_rd), 'h40);
                chk(fail == fs, poll ? "R7" : "R6", "fail bit", int'(fail), int'(fs));
            end
        end
        @(negedge clk);
        chk(!done, "R11", "done one cycle", int'(done), 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ce_n && we_n && re_n && !cle && !ale && !busy, "R10", "idle after reset",
            {ce_n, we_n, re_n, cle, ale, busy}, 'b111000);

        run_case(0, 11'd5,    11'd0,    0, 0, 30,  5000, 0, 0);
        run_case(1, 11'd4,    11'd5,    1, 1, 80,  5000, 0, 0);
        run_case(1, 11'd5,    11'd4,    0, 1, 20,  5000, 0, 0);
        run_case(1, 11'h7FE,  11'h7FF,  1, 0, 150, 5000, 0, 0);
        run_case(1, 11'd4,    11'd6,    0, 0, 20,  5000, 1, 0);
        run_case(1, 11'd4,    11'd9,    0, 0, 20,  5000, 1, 0);

        for (int n = 0; n < 24; n++) begin
            bit two, poll, fs;
            logic [BLK_W-1:0] a;
            two  = $urandom % 2;
            poll = $urandom % 2;
            fs   = $urandom % 2;
            a    = BLK_W'($urandom);
            run_case(two, a, a ^ 11'd1, poll, fs, 10 + ($urandom % 200), 5000, 0, 0);
        end

        run_case(0, 11'd12, 11'd0,  0, 0, 100000, 60, 0, 1);
        run_case(1, 11'd8,  11'd9,  1, 1, 100000, 60, 0, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule